// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is the control core of a single-item vending machine. It keeps a running credit that grows when one of two coin push buttons is pressed: one adds 2, the other adds 5. A buy push button either releases the item or raises an alarm. The item price comes from a 5-bit switch input in the range 1 to 31. Credit is never paid back. Whatever remains after a purchase stays for the next one. The price and the credit are brought out as plain binary values, so an external display stage can show them. A coin counter raises a compartment-full flag once more than 20 coins have gone in.

Every button passes through a rising-edge detector. A press that is held adds one coin or makes at most one deduction. Purchases are run by a four-state machine:

- IDLE waits for a buy edge.
- JUDGE compares credit with price. It stays in JUDGE while coin edges keep arriving, so a coin pressed at the same time as buy is counted before the decision.
- PAY drives the release output.
- DENY drives the alarm output.

The named transitions are:

- IDLE→JUDGE on a buy edge.
- JUDGE→JUDGE on a coin edge.
- JUDGE→PAY when there is no coin edge and credit ≥ price. The price is deducted on this transition.
- JUDGE→DENY when there is no coin edge and credit < price.
- PAY→IDLE and DENY→IDLE when buy is low.

The datapath has one adder/subtractor, selected by an operand multiplexer, feeding an 8-bit credit register. That register saturates at 255 and does not wrap.

Top module: `vend_ctrl`

## Requirements
- R1: Synchronous reset (rst high) clears credit to 0, clears the coin count, drives release_o, alarm_o and full_o low, and returns the machine to IDLE.
- R2: A rising edge on coin_two adds 2 and a rising edge on coin_five adds 5 to credit, with the result visible one clock after the edge. Both rising together add 7. A button that stays high adds nothing more.
- R3: A coin addition that would exceed 255 leaves credit at 255.
- R4: A buy rising edge with credit ≥ price_sw leads to release_o high from two clocks after the edge. Release stays high until the first clock at which buy_btn is sampled low. Credit drops by the price exactly once, in the cycle release_o rises.
- R5: A buy rising edge with credit < price_sw leads to alarm_o high from two clocks after the edge. Alarm stays high until buy_btn is sampled low. No deduction is made.
- R6: A coin edge in the same cycle as the buy edge, or while in JUDGE, is added before the credit is compared with the price.
- R7: The coin count increases by the number of coin edges and saturates at 63. full_o is high while the count is above 20.
- R8: price_o equals price_sw combinationally, and credit_o shows the credit register.
- R9: release_o and alarm_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| price_sw | input | 5 | Item price, 1 to 31 |
| coin_two | input | 1 | Coin button worth 2 |
| coin_five | input | 1 | Coin button worth 5 |
| buy_btn | input | 1 | Buy button |
| release_o | output | 1 | Item release, held while buy is held after a paid purchase |
| alarm_o | output | 1 | Insufficient-credit alarm, held while buy is held |
| full_o | output | 1 | Coin compartment holds more than 20 coins |
| price_o | output | 5 | Price for display |
| credit_o | output | 8 | Current credit for display |

## Verification
A stale edge-detector register shows on credit_o within one clock of the next press: the press is either counted twice or missed. A wrong decision in JUDGE shows two clocks after the buy edge, when release_o and alarm_o swap or credit_o fails to fall by the price. A machine stuck in PAY or DENY shows up when the output stays high after buy_btn drops. A cycle-level reference model is compared with every output on every clock, so any divergence is reported in the cycle it first appears.

// File: rtl/vend_pkg.sv
package vend_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_JUDGE = 2'd1,
        ST_PAY   = 2'd2,
        ST_DENY  = 2'd3
    } vend_state_t;
endpackage

// File: rtl/rise_det.sv
module rise_det #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= din;
    end

    for (genvar g = 0; g < N; g++) begin : g_bit
        assign rise[g] = din[g] & ~prev_q[g];

        // R2: a held button yields one edge only
        p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
            rise[g] |=> !rise[g]);
    end
endmodule

// File: rtl/vend_credit.sv
module vend_credit #(
    parameter int CW = 8,
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          add_en,
    input  logic [CW-1:0] add_amt,
    input  logic          sub_en,
    input  logic [PW-1:0] price,
    output logic [CW-1:0] credit,
    output logic          enough
);
    logic [CW-1:0] credit_q;
    logic [CW:0]   opnd;
    logic [CW:0]   res;

    // single adder/subtractor: operand mux, invert and carry-in for subtract
    always_comb begin
        opnd = sub_en ? {{(CW+1-PW){1'b0}}, price} : {1'b0, add_amt};
        res  = {1'b0, credit_q} + (opnd ^ {(CW+1){sub_en}}) + {{CW{1'b0}}, sub_en};
    end

    always_ff @(posedge clk) begin
        if (rst)
            credit_q <= '0;
        else if (sub_en || add_en)
            credit_q <= (!sub_en && res[CW]) ? {CW{1'b1}} : res[CW-1:0];
    end

    assign credit = credit_q;
    assign enough = credit_q >= {{(CW-PW){1'b0}}, price};

    // R4: a deduction is only requested when credit covers the price
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        sub_en |-> enough);
    // R3: adding a coin never makes credit smaller
    p_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (add_en && !sub_en) |=> credit_q >= $past(credit_q));
endmodule

// File: rtl/coin_tally.sv
module coin_tally #(
    parameter int NW    = 6,
    parameter int LIMIT = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] inc,
    output logic       full
);
    localparam logic [NW-1:0] CMAX = {NW{1'b1}};
    localparam logic [NW-1:0] LIM  = NW'(LIMIT);

    logic [NW-1:0] count_q;
    logic [NW:0]   sum;

    assign sum = {1'b0, count_q} + {{(NW-1){1'b0}}, inc};

    always_ff @(posedge clk) begin
        if (rst)         count_q <= '0;
        else if (sum[NW]) count_q <= CMAX;
        else             count_q <= sum[NW-1:0];
    end

    assign full = count_q > LIM;

    // R7: the full flag only appears after a coin was counted
    p_full_after_coin_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(inc != 2'd0));
endmodule

// File: rtl/vend_fsm.sv
module vend_fsm
    import vend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic buy_rise,
    input  logic buy_lvl,
    input  logic coin_seen,
    input  logic enough,
    output logic add_en,
    output logic sub_en,
    output logic release_o,
    output logic alarm_o
);
    vend_state_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (buy_rise) st_d = ST_JUDGE;
            ST_JUDGE: if (!coin_seen) st_d = enough ? ST_PAY : ST_DENY;
            ST_PAY:   if (!buy_lvl) st_d = ST_IDLE;
            ST_DENY:  if (!buy_lvl) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        add_en    = coin_seen;
        sub_en    = 1'b0;
        release_o = 1'b0;
        alarm_o   = 1'b0;
        unique case (st_q)
            ST_IDLE:  ;
            ST_JUDGE: sub_en = !coin_seen && enough;
            ST_PAY:   release_o = 1'b1;
            ST_DENY:  alarm_o = 1'b1;
            default:  ;
        endcase
    end

    // R6: JUDGE waits only while coins arrive
    p_judge_leaves_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_JUDGE && !coin_seen) |=> st_q != ST_JUDGE);
    // R4/R5: outputs end once buy is sampled low
    p_hold_ends_r4: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_PAY || st_q == ST_DENY) && !buy_lvl) |=> st_q == ST_IDLE);
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl #(
    parameter int CW       = 8,
    parameter int PW       = 5,
    parameter int CNT_W    = 6,
    parameter int FULL_LIM = 20,
    parameter int COIN_LO  = 2,
    parameter int COIN_HI  = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] price_sw,
    input  logic          coin_two,
    input  logic          coin_five,
    input  logic          buy_btn,
    output logic          release_o,
    output logic          alarm_o,
    output logic          full_o,
    output logic [PW-1:0] price_o,
    output logic [CW-1:0] credit_o
);
    localparam int NBTN = 3;

    logic [NBTN-1:0] rise;
    logic [CW-1:0]   add_amt;
    logic            add_en, sub_en, enough;

    rise_det #(.N(NBTN)) u_edge (
        .clk (clk),
        .rst (rst),
        .din ({buy_btn, coin_five, coin_two}),
        .rise(rise)
    );

    assign add_amt = (rise[0] ? CW'(COIN_LO) : '0) + (rise[1] ? CW'(COIN_HI) : '0);

    vend_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .buy_rise (rise[2]),
        .buy_lvl  (buy_btn),
        .coin_seen(rise[0] | rise[1]),
        .enough   (enough),
        .add_en   (add_en),
        .sub_en   (sub_en),
        .release_o(release_o),
        .alarm_o  (alarm_o)
    );

    vend_credit #(.CW(CW), .PW(PW)) u_dp (
        .clk    (clk),
        .rst    (rst),
        .add_en (add_en),
        .add_amt(add_amt),
        .sub_en (sub_en),
        .price  (price_sw),
        .credit (credit_o),
        .enough (enough)
    );

    coin_tally #(.NW(CNT_W), .LIMIT(FULL_LIM)) u_tally (
        .clk (clk),
        .rst (rst),
        .inc ({1'b0, rise[0]} + {1'b0, rise[1]}),
        .full(full_o)
    );

    assign price_o = price_sw;

    // R9: release and alarm are exclusive
    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(release_o && alarm_o));
    // R5: entering the alarm state leaves credit untouched
    p_alarm_keeps_credit_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_o) |-> credit_o == $past(credit_o));
    // R4: the release cycle shows the credit reduced by the price
    p_release_charges_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(release_o) |-> credit_o == CW'($past(credit_o) - CW'($past(price_sw))));
endmodule

// File: tb/tb_vend_ctrl.sv
module tb_vend_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] price_sw = 5'd1;
    logic       coin_two = 1'b0, coin_five = 1'b0, buy_btn = 1'b0;
    logic       release_o, alarm_o, full_o;
    logic [4:0] price_o;
    logic [7:0] credit_o;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // reference model state
    int m_st, m_credit, m_cnt;
    bit m_p2, m_p5, m_pb;

    always #5 clk = ~clk;

    vend_ctrl dut (
        .clk(clk), .rst(rst), .price_sw(price_sw), .coin_two(coin_two),
        .coin_five(coin_five), .buy_btn(buy_btn), .release_o(release_o),
        .alarm_o(alarm_o), .full_o(full_o), .price_o(price_o), .credit_o(credit_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int sat_add(input int c, input int a);
        return (c + a > 255) ? 255 : c + a;
    endfunction

    // one clock: drive at negedge, advance model, compare at next negedge
    task automatic step(input bit t, input bit f, input bit b, input int p, input bit r);
        bit rt, rf, rb;
        int amt;
        coin_two = t; coin_five = f; buy_btn = b; price_sw = 5'(p); rst = r;
        if (r) begin
            m_st = 0; m_credit = 0; m_cnt = 0; m_p2 = 0; m_p5 = 0; m_pb = 0;
        end else begin
            rt = t && !m_p2; rf = f && !m_p5; rb = b && !m_pb;
            amt = (rt ? 2 : 0) + (rf ? 5 : 0);
            case (m_st)
                0: begin m_credit = sat_add(m_credit, amt); if (rb) m_st = 1; end
                1: begin
                    if (rt || rf) m_credit = sat_add(m_credit, amt);
                    else if (m_credit >= p) begin m_credit -= p; m_st = 2; end
                    else m_st = 3;
                end
                default: begin m_credit = sat_add(m_credit, amt); if (!b) m_st = 0; end
            endcase
            m_cnt = m_cnt + int'(rt) + int'(rf);
            if (m_cnt > 63) m_cnt = 63;
            m_p2 = t; m_p5 = f; m_pb = b;
        end
        @(posedge clk);
        @(negedge clk);
        check("credit_o model R2 R3 R4 R5 R6", int'(credit_o), m_credit);
        check("release_o model R4", int'(release_o), int'(m_st == 2));
        check("alarm_o model R5", int'(alarm_o), int'(m_st == 3));
        check("full_o model R7", int'(full_o), int'(m_cnt > 20));
        check("price_o R8", int'(price_o), p);
        check("exclusive R9", int'(release_o && alarm_o), 0);
    endtask

    task automatic press(input bit t, input bit f, input int p, input int hold);
        for (int i = 0; i < hold; i++) step(t, f, 1'b0, p, 1'b0);
        step(1'b0, 1'b0, 1'b0, p, 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        int p;
        bit b;
        seed = $urandom(32'h5EED_1234);
        @(negedge clk);
        step(0, 0, 0, 7, 1);
        step(0, 0, 0, 7, 1);
        // R1 reset state
        check("R1 credit", int'(credit_o), 0);
        check("R1 release", int'(release_o), 0);
        check("R1 alarm", int'(alarm_o), 0);
        check("R1 full", int'(full_o), 0);

        // R2: held presses count once, both together add 7
        press(1, 0, 7, 3);
        check("R2 two", int'(credit_o), 2);
        press(0, 1, 7, 4);
        check("R2 five", int'(credit_o), 7);
        press(1, 1, 7, 1);
        check("R2 both", int'(credit_o), 14);

        // R5: insufficient credit, alarm held, credit unchanged
        step(0, 0, 1, 20, 0);
        step(0, 0, 1, 20, 0);
        check("R5 alarm up", int'(alarm_o), 1);
        for (int i = 0; i < 3; i++) step(0, 0, 1, 20, 0);
        check("R5 alarm held", int'(alarm_o), 1);
        check("R5 credit kept", int'(credit_o), 14);
        step(0, 0, 0, 20, 0);
        check("R5 alarm drops", int'(alarm_o), 0);

        // R4: paid purchase held long deducts once
        step(0, 0, 1, 7, 0);
        step(0, 0, 1, 7, 0);
        check("R4 release up", int'(release_o), 1);
        check("R4 charged", int'(credit_o), 7);
        for (int i = 0; i < 4; i++) step(0, 0, 1, 7, 0);
        check("R4 single deduction", int'(credit_o), 7);
        step(0, 0, 0, 7, 0);
        check("R4 release drops", int'(release_o), 0);

        // R6: coin with buy edge counts first: 7+2=9 covers price 9
        step(1, 0, 1, 9, 0);
        step(0, 0, 1, 9, 0);
        check("R6 release", int'(release_o), 1);
        check("R6 credit", int'(credit_o), 0);
        step(0, 0, 0, 9, 0);
        check("R8 price_o", int'(price_o), 9);

        // R7 / R3: full flag and saturation
        step(0, 0, 0, 9, 1);
        for (int i = 0; i < 20; i++) press(1, 0, 9, 1);
        check("R7 twenty not full", int'(full_o), 0);
        press(1, 0, 9, 1);
        check("R7 twentyone full", int'(full_o), 1);
        for (int i = 0; i < 45; i++) press(0, 1, 9, 1);
        check("R3 saturated", int'(credit_o), 255);
        check("R7 still full", int'(full_o), 1);

        // constrained random mix
        step(0, 0, 0, 9, 1);
        p = 9; b = 0;
        for (int i = 0; i < 4000; i++) begin
            if (!b && ($urandom % 8 == 0)) p = 1 + int'($urandom % 31);
            if ($urandom % 5 == 0) b = !b;
            step(($urandom % 4) == 0, ($urandom % 5) == 0, b, p, ($urandom % 1500) == 0);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule